// File: doc/BRIEF.md
# Zero-Latency Frame Serializer (Transmit Side)

This block packs one parallel word per slow-clock period into a frame of bit slots. It sends the frame out on a single pin at double data rate, two bits on each fast serial clock cycle. The slow clock and the fast clock come from the same source and are phase-related. A frame starts on a rising edge of the slow clock and leaves the pin completely before the next rising edge. The receiving side therefore sees the word in the same slow cycle, with no added cycle of latency.

A frame has `FRAME_SLOTS` slots. The payload fills the first `PAYLOAD_BITS` slots, and every later slot is driven as zero. The payload is a fixed training word while the link is being aligned, and the user word once the `use_user` control is raised. The choice of payload is made once per frame. Inside the fast domain, the slow clock is sampled as a data signal to find its rising edge. `SLACK_STAGES` delays the point where the parallel inputs are captured, which gives the parallel-to-serial path more time. Each extra stage costs two payload slots of frame room.

Top module: `zlt_frame_tx`

## Requirements
- R1: While `rst_n` is low, `ser_pin` is 0 in both halves of the serial clock and `training_active` is 1, whatever the payload inputs do.
- R2: With `SLACK_STAGES` = 1, slot 0 of a frame is on the pin in the high half of the serial cycle that begins on the third rising serial edge after the slow clock's rising edge.
- R3: Slots leave least-significant first. Slot 2k is on the pin in the high half of serial cycle k of the frame, and slot 2k+1 is on the pin in the low half.
- R4: Slots from `PAYLOAD_BITS` up to `FRAME_SLOTS`-1 are always 0, even when the payload is all ones.
- R5: A frame carries `train_word` when `use_user` was 0 at its capture point, and `user_word` when it was 1. The word that is not selected has no effect on the pin.
- R6: `use_user` and the payload words are captured only once per frame. A change in the middle of a frame leaves the rest of that frame unchanged and first shows in the next frame.
- R7: `training_active` is 1 after a frame captured with `use_user` = 0, and 0 after a frame captured with `use_user` = 1. It changes only at a capture point.
- R8: Each `SLACK_STAGES` step above 1 moves the whole frame one serial cycle later on the pin.
- R9: Frames are back to back. The last slot pair of one frame is followed in the next serial cycle by the first slot pair of the next frame, and captures come exactly `FRAME_SLOTS`/2 serial cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_par | input | 1 | Slow parallel clock, sampled as data in the serial domain |
| clk_ser | input | 1 | Fast serial clock, two slots per cycle |
| rst_n | input | 1 | Active-low reset, sampled on serial clock edges; the pin is forced low at once |
| train_word | input | PAYLOAD_BITS | Training payload |
| user_word | input | PAYLOAD_BITS | User payload |
| use_user | input | 1 | 1 selects `user_word`, 0 selects `train_word`, applied per frame |
| ser_pin | output | 1 | Serial output, double data rate |
| training_active | output | 1 | 1 while the frames being sent carry the training word |

## Verification
The assertions assume that the slow clock period is exactly `FRAME_SLOTS`/2 serial cycles. They also assume that slow-clock edges fall a little after a serial rising edge, so that the sampler never sees them change at the edge. The bench builds the slow clock by dividing the serial clock, with a one-nanosecond lag. It changes the payload inputs only just after a slow-clock edge, or in mid-frame when it tests R6. Two instances share the inputs, one with one slack stage and one with two. Every frame is therefore checked against both timings.

// File: rtl/zlt_pkg.sv
// Shared types for the zero-latency frame transmitter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package zlt_pkg;

    // Payload source of the frame currently leaving the pin
    typedef enum logic {
        MODE_TRAIN = 1'b0,
        MODE_USER  = 1'b1
    } tx_mode_e;

    // Number of slot pairs (serial cycles) in one frame
    function automatic int pairs_per_frame(input int slots);
        return slots / 2;
    endfunction

endpackage

// File: rtl/zlt_edge_detect.sv
// Samples the slow clock as data in the serial domain and flags its rising edge.
// Assumes: the slow clock changes a little after a serial rising edge; SYNC_STAGES >= 2.
// The stages reset to ones so that no false edge appears after reset.
module zlt_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ser,
    input  logic rst_n,
    input  logic clk_par_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] smp_q;

    // Shift the sampled slow clock through the stage chain
    always_ff @(posedge clk_ser) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else begin
            smp_q <= {smp_q[SYNC_STAGES-2:0], clk_par_i};
        end
    end

    // Rising edge: newer stage high, older stage low
    assign rise_o = smp_q[SYNC_STAGES-2] & ~smp_q[SYNC_STAGES-1];

endmodule

// File: rtl/zlt_slack_line.sv
// Delays the edge pulse by SLACK_STAGES-1 serial cycles to form the capture pulse.
// Assumes: SLACK_STAGES >= 1; a value of 1 adds no delay.
module zlt_slack_line #(
    parameter int SLACK_STAGES = 1
) (
    input  logic clk_ser,
    input  logic rst_n,
    input  logic rise_i,
    output logic load_o
);

    generate
        if (SLACK_STAGES <= 1) begin : g_direct
            // No extra slack: capture on the detected edge itself
            assign load_o = rise_i;
        end else begin : g_delay
            localparam int DLY = SLACK_STAGES - 1;
            logic [DLY-1:0] dly_q;

            // Carry the edge pulse down the delay line
            always_ff @(posedge clk_ser) begin
                if (!rst_n) begin
                    dly_q <= '0;
                end else begin
                    dly_q <= (dly_q << 1) | DLY'(rise_i);
                end
            end

            assign load_o = dly_q[DLY-1];
        end
    endgenerate

endmodule

// File: rtl/zlt_frame_loader.sv
// Picks the payload, zero-pads it into a full frame on a capture pulse, and
// shifts it down two slots per serial cycle. Records the mode of the frame.
// Assumes: FRAME_SLOTS even, PAYLOAD_BITS even and not above FRAME_SLOTS.
module zlt_frame_loader
    import zlt_pkg::*;
#(
    parameter int FRAME_SLOTS  = 16,
    parameter int PAYLOAD_BITS = 10
) (
    input  logic                    clk_ser,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    use_user_i,
    input  logic [PAYLOAD_BITS-1:0] train_i,
    input  logic [PAYLOAD_BITS-1:0] user_i,
    output logic [1:0]              pair_o,
    output tx_mode_e                mode_o
);

    logic [PAYLOAD_BITS-1:0] payload;
    logic [FRAME_SLOTS-1:0]  frame_q;
    tx_mode_e                mode_q;

    // Select the payload source for the next capture
    always_comb begin
        payload = use_user_i ? user_i : train_i;
    end

    // Capture a zero-padded frame, or shift the current one by a pair
    always_ff @(posedge clk_ser) begin
        if (!rst_n) begin
            frame_q <= '0;
            mode_q  <= MODE_TRAIN;
        end else if (load_i) begin
            frame_q <= FRAME_SLOTS'(payload);
            mode_q  <= use_user_i ? MODE_USER : MODE_TRAIN;
        end else begin
            frame_q <= frame_q >> 2;
        end
    end

    assign pair_o = frame_q[1:0];
    assign mode_o = mode_q;

endmodule

// File: rtl/zlt_ddr_out.sv
// Behavioural double-data-rate output register: even slot in the high half,
// odd slot in the low half. The pin is forced low while reset is held.
// Assumes: pair_i is stable at the serial rising edge.
module zlt_ddr_out (
    input  logic       clk_ser,
    input  logic       rst_n,
    input  logic [1:0] pair_i,
    output logic       rise_o,
    output logic       fall_o,
    output logic       pin_o
);

    logic rise_q;
    logic fall_q;

    // Register both slots of the pair on the rising edge
    always_ff @(posedge clk_ser) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= pair_i[0];
            fall_q <= pair_i[1];
        end
    end

    // Clock-phase mux models the output register; reset gates it low
    assign pin_o  = rst_n & (clk_ser ? rise_q : fall_q);
    assign rise_o = rise_q;
    assign fall_o = fall_q;

endmodule

// File: rtl/zlt_frame_tx.sv
// Zero-latency frame transmitter top. It finds the slow-clock edge, waits the
// slack stages, captures a padded frame and sends it at double data rate so the
// frame ends before the next slow edge.
// Assumes: slow period = FRAME_SLOTS/2 serial cycles, both clocks from one source,
// PAYLOAD_BITS + 2*(SLACK_STAGES-1) leaves room inside FRAME_SLOTS.
module zlt_frame_tx
    import zlt_pkg::*;
#(
    parameter int FRAME_SLOTS  = 16,
    parameter int PAYLOAD_BITS = 10,
    parameter int SLACK_STAGES = 1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk_par,
    input  logic                    clk_ser,
    input  logic                    rst_n,
    input  logic [PAYLOAD_BITS-1:0] train_word,
    input  logic [PAYLOAD_BITS-1:0] user_word,
    input  logic                    use_user,
    output logic                    ser_pin,
    output logic                    training_active
);

    logic       par_rise;
    logic       load_pulse;
    logic [1:0] slot_pair;
    tx_mode_e   frame_mode;
    logic       rise_bit;
    logic       fall_bit;

    zlt_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk_ser  (clk_ser),
        .rst_n    (rst_n),
        .clk_par_i(clk_par),
        .rise_o   (par_rise)
    );

    zlt_slack_line #(
        .SLACK_STAGES(SLACK_STAGES)
    ) u_slack (
        .clk_ser(clk_ser),
        .rst_n  (rst_n),
        .rise_i (par_rise),
        .load_o (load_pulse)
    );

    zlt_frame_loader #(
        .FRAME_SLOTS (FRAME_SLOTS),
        .PAYLOAD_BITS(PAYLOAD_BITS)
    ) u_loader (
        .clk_ser   (clk_ser),
        .rst_n     (rst_n),
        .load_i    (load_pulse),
        .use_user_i(use_user),
        .train_i   (train_word),
        .user_i    (user_word),
        .pair_o    (slot_pair),
        .mode_o    (frame_mode)
    );

    zlt_ddr_out u_ddr (
        .clk_ser(clk_ser),
        .rst_n  (rst_n),
        .pair_i (slot_pair),
        .rise_o (rise_bit),
        .fall_o (fall_bit),
        .pin_o  (ser_pin)
    );

    // Status flag follows the mode of the captured frame
    assign training_active = (frame_mode == MODE_TRAIN);

endmodule

// File: rtl/zlt_frame_tx_chk.sv
// Assertion checker for zlt_frame_tx, attached by bind below.
// Assumes: the slow clock period is exactly FRAME_SLOTS/2 serial cycles.
module zlt_frame_tx_chk #(
    parameter int FRAME_SLOTS  = 16,
    parameter int PAYLOAD_BITS = 10
) (
    input logic clk_ser,
    input logic rst_n,
    input logic use_user,
    input logic load_pulse,
    input logic rise_bit,
    input logic fall_bit,
    input logic ser_pin,
    input logic training_active
);

    localparam int HALF = FRAME_SLOTS / 2;
    localparam int CW   = $clog2(HALF + 1) + 1;

    logic [CW-1:0] since_load;
    logic          seen_load;

    // Count serial cycles since the last capture, saturating
    always_ff @(posedge clk_ser) begin
        if (!rst_n) begin
            since_load <= '0;
            seen_load  <= 1'b0;
        end else if (load_pulse) begin
            since_load <= '0;
            seen_load  <= 1'b1;
        end else if (int'(since_load) < HALF) begin
            since_load <= since_load + 1'b1;
        end
    end

    AST_PIN_LOW_IN_RESET: assert property (@(negedge clk_ser)
        !rst_n |-> !ser_pin); // R1

    AST_FLAG_SET_IN_RESET: assert property (@(posedge clk_ser)
        !rst_n |=> training_active); // R1

    AST_FLAG_HOLDS_MIDFRAME: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (!load_pulse && $past(rst_n)) |=> $stable(training_active)); // R6

    AST_FLAG_FOLLOWS_MODE: assert property (@(posedge clk_ser) disable iff (!rst_n)
        load_pulse |=> (training_active == !$past(use_user))); // R7

    AST_FRAME_PERIOD: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (load_pulse && seen_load) |-> (int'(since_load) == HALF - 1)); // R9

    AST_CLIPPED_ZERO: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (seen_load && int'(since_load) >= PAYLOAD_BITS / 2 + 1 && int'(since_load) <= HALF - 1)
        |-> (!rise_bit && !fall_bit)); // R4

endmodule

bind zlt_frame_tx zlt_frame_tx_chk #(
    .FRAME_SLOTS (FRAME_SLOTS),
    .PAYLOAD_BITS(PAYLOAD_BITS)
) u_chk (
    .clk_ser        (clk_ser),
    .rst_n          (rst_n),
    .use_user       (use_user),
    .load_pulse     (load_pulse),
    .rise_bit       (rise_bit),
    .fall_bit       (fall_bit),
    .ser_pin        (ser_pin),
    .training_active(training_active)
);

// File: tb/zlt_frame_tx_test.sv
// Directed bench: two instances (one and two slack stages) share the inputs.
module zlt_frame_tx_test;

    localparam int FW   = 16;
    localparam int DW   = 10;
    localparam int DB   = 8;
    localparam int HALF = FW / 2;

    logic          clk_ser = 1'b0;
    logic          clk_par = 1'b0;
    logic          rst_n   = 1'b0;
    logic [DW-1:0] train_word = '0;
    logic [DW-1:0] user_word  = '0;
    logic          use_user   = 1'b0;
    logic          pin_a, pin_b, act_a, act_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    zlt_frame_tx #(.FRAME_SLOTS(FW), .PAYLOAD_BITS(DW), .SLACK_STAGES(1)) uut (
        .clk_par(clk_par), .clk_ser(clk_ser), .rst_n(rst_n),
        .train_word(train_word), .user_word(user_word), .use_user(use_user),
        .ser_pin(pin_a), .training_active(act_a));

    zlt_frame_tx #(.FRAME_SLOTS(FW), .PAYLOAD_BITS(DB), .SLACK_STAGES(2)) uut_s (
        .clk_par(clk_par), .clk_ser(clk_ser), .rst_n(rst_n),
        .train_word(train_word[DB-1:0]), .user_word(user_word[DB-1:0]), .use_user(use_user),
        .ser_pin(pin_b), .training_active(act_b));

    // 50 MHz serial clock
    always #10 clk_ser = ~clk_ser;

    // Slow clock: divide by HALF, lagging the serial edge by 1 ns
    initial begin
        forever begin
            repeat (HALF / 2) @(posedge clk_ser);
            #1 clk_par = ~clk_par;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Send one frame, capture it on both pins, and check it
    task automatic run_frame(input logic [DW-1:0] tw, input logic [DW-1:0] uw,
                             input logic sel, input logic flip, input string req);
        logic [FW-1:0] got_a, got_b, exp_a, exp_b;
        logic [DW-1:0] pay, pay_next;
        logic [1:0]    nxt;
        logic          fa, fb;
        got_a = '0; got_b = '0; nxt = '0; fa = 1'b0; fb = 1'b0;
        @(posedge clk_par);
        #2;
        train_word = tw; user_word = uw; use_user = sel;
        repeat (2) @(posedge clk_ser);
        for (int j = 0; j <= HALF; j++) begin
            @(posedge clk_ser);
            #5;
            if (j < HALF) got_a[2*j] = pin_a; else nxt[0] = pin_a;
            if (j >= 1) got_b[2*(j-1)] = pin_b;
            if (j == 0) begin fa = act_a; fb = act_b; end
            #10;
            if (j < HALF) got_a[2*j+1] = pin_a; else nxt[1] = pin_a;
            if (j >= 1) got_b[2*(j-1)+1] = pin_b;
            if (flip && j == 2) use_user = ~sel;
        end
        pay      = sel ? uw : tw;
        pay_next = flip ? (sel ? tw : uw) : pay;
        exp_a    = FW'(pay);
        exp_b    = FW'(pay[DB-1:0]);
        chk(got_a == exp_a, req, "frame, one slack stage", got_a, exp_a);
        chk(got_a[FW-1:DW] == '0, "R4", "clipped slots", FW'(got_a[FW-1:DW]), '0);
        chk(got_b == exp_b, "R8", "frame one cycle later, two slack stages", got_b, exp_b);
        chk(nxt == pay_next[1:0], "R9", "first pair of next frame", FW'(nxt), FW'(pay_next[1:0]));
        chk(fa == !sel && fb == !sel, "R7", "training flag", FW'({fb, fa}), FW'({!sel, !sel}));
    endtask

    task automatic test_reset();
        train_word = '1; user_word = '1; use_user = 1'b1;
        repeat (20) begin
            @(posedge clk_ser);
            #5 chk(pin_a == 1'b0 && pin_b == 1'b0, "R1", "pin high half in reset", FW'({pin_b, pin_a}), '0);
            #10 chk(pin_a == 1'b0 && pin_b == 1'b0, "R1", "pin low half in reset", FW'({pin_b, pin_a}), '0);
        end
        chk(act_a && act_b, "R1", "training flag in reset", FW'({act_b, act_a}), FW'(2'b11));
        #3 rst_n = 1'b1;
        @(posedge clk_ser);
        #5 chk(pin_a == 1'b0, "R1", "pin idle after release", FW'(pin_a), '0);
    endtask

    task automatic test_training();
        run_frame(10'h2B5, 10'h0F3, 1'b0, 1'b0, "R2");
        run_frame(10'h155, 10'h3FF, 1'b0, 1'b0, "R5");
    endtask

    task automatic test_user();
        run_frame(10'h3FF, 10'h0F3, 1'b1, 1'b0, "R3");
        run_frame(10'h000, 10'h2C1, 1'b1, 1'b0, "R5");
    endtask

    task automatic test_clip();
        run_frame(10'h000, 10'h3FF, 1'b1, 1'b0, "R4");
        run_frame(10'h3FF, 10'h000, 1'b0, 1'b0, "R4");
    endtask

    task automatic test_switch();
        run_frame(10'h1A6, 10'h259, 1'b0, 1'b1, "R6");
        run_frame(10'h1A6, 10'h259, 1'b1, 1'b1, "R6");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_training();
        test_user();
        test_clip();
        test_switch();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule